// File: doc/BRIEF.md
# Two-Wire Debug Link Frame Engine

This block is the master side of a two-wire serial debug and programming link. It drives a clock line and shares one bidirectional data line with the target. A host asks for one of four link operations: address write, address read, data write or data read. The engine builds the whole frame one bit cycle at a time. It turns the data line around inside the frame and, for data transfers, waits for the target's ready handshake. It returns read data together with a completion status. It also produces the long link reset pulse that must come before any frame.

Bit timing comes from a divider. Each bit cycle holds the clock low for `DIV` system clocks and high for at least `DIV` system clocks. The host side uses a start, busy and done handshake. A frame request and a link reset request are accepted only while the engine is idle.

Top module: `twd_master`

## Requirements
- R1: The clock output idles high and the data driver is off. In each bit cycle, the clock falls in the same cycle that the new data value and driver enable appear. The clock stays low for exactly `DIV` system clocks, with data and enable unchanged. The data input is sampled at the end of the low phase.
- R2: Every frame begins with one start bit sent with the driver disabled. The driver is enabled for the bits that follow.
- R3: `op_i` encodes 0 = address write, 1 = address read, 2 = data write, 3 = data read. The two instruction bits go out in this order: address write 1 then 1, address read 0 then 1, data write 1 then 0, data read 0 then 0.
- R4: Data operations send `len_i` (byte count minus one) as 2 bits, LSB first. Addresses (8 bits) and write data (8*(len_i+1) bits) are sent LSB first.
- R5: An address write sends the 8 address bits, then one stop bit with the driver off, then completes with status 0.
- R6: Address read, data write and data read release the driver for one turnaround bit before any target bit is sampled. An address read then samples 8 bits, LSB first, into `rdata_o[7:0]` and completes with status 0.
- R7: After the turnaround bit, a data write or data read clocks wait bits until a 1 is sampled. A data write then completes with status 0. A data read then samples 8*(len_i+1) bits, LSB first, into `rdata_o`, with the upper bits zero, and completes with status 0.
- R8: If 128 wait bits in a row sample 0, the frame ends after the 128th wait bit with status 1 (shift timeout), and no data bits are clocked. A 1 on the 128th wait bit still counts as success.
- R9: A link reset holds the clock low for `RST_LO_CYC` system clocks, then high for `RST_HI_CYC` system clocks, then completes with status 0. It takes priority over a frame request made in the same cycle.
- R10: `busy_o` is high from acceptance through completion. `done_o` is a one-cycle pulse, and `status_o` and `rdata_o` are valid during it. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Frame request, sampled while idle |
| op_i | input | 2 | Operation code (R3) |
| len_i | input | 2 | Byte count minus one for data operations |
| addr_i | input | 8 | Address for address write |
| wdata_i | input | 32 | Write data, LSB first on the line |
| link_rst_i | input | 1 | Link reset request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 success, 1 shift timeout |
| rdata_o | output | 32 | Read data |
| dck_o | output | 1 | Link clock |
| dat_i | input | 1 | Data line input |
| dat_o | output | 1 | Data line output value |
| dat_oe_o | output | 1 | Data line driver enable |

## Verification
A target model on the bench answers every bit cycle and records what the engine drives. Each captured frame is compared bit by bit with a frame built arithmetically from the operation, the length and the data. The sweep covers all four operations and all four byte counts, with several address and data patterns. Asymmetric patterns expose bit-order and length errors, and wait runs of 0, 3 and 127 zeros separate correct handshake counting from off-by-one retry limits. Long zero runs confirm that a timeout cuts the frame before any data. A request during a frame, and a reset request together with a frame request, check the acceptance rules.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int DATA_W = 32;
  localparam int BIT_CW = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OP_AWR = 2'd0,
    OP_ARD = 2'd1,
    OP_DWR = 2'd2,
    OP_DRD = 2'd3
  } op_e;

  localparam logic [1:0] STAT_OK  = 2'd0;
  localparam logic [1:0] STAT_TMO = 2'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_LRST, S_START, S_INS, S_LEN, S_ADDR, S_WDAT,
    S_STOP, S_TURN, S_WAIT, S_RDAT, S_DONE
  } seq_e;
endpackage

// File: rtl/twd_bitcyc.sv
module twd_bitcyc #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic bit_i,
  input  logic oe_i,
  input  logic dat_i,
  output logic dck_o,
  output logic dat_o,
  output logic oe_o,
  output logic smp_o,
  output logic idle_o,
  output logic done_o
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV + 1) : 1;

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} ph_e;

  ph_e            ph_q;
  logic [DCW-1:0] cnt_q;
  logic           dck_q, dat_q, oe_q, smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      dck_q <= 1'b1;
      dat_q <= 1'b0;
      oe_q  <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          dat_q <= bit_i;
          oe_q  <= oe_i;
          dck_q <= 1'b0;
          cnt_q <= DCW'(DIV - 1);
          ph_q  <= PH_LO;
        end
        PH_LO: if (cnt_q == '0) begin
          smp_q <= dat_i;
          dck_q <= 1'b1;
          cnt_q <= DCW'(DIV - 1);
          ph_q  <= PH_HI;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_HI: if (cnt_q == '0) ph_q <= PH_IDLE;
               else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign dck_o  = dck_q;
  assign dat_o  = dat_q;
  assign oe_o   = oe_q;
  assign smp_o  = smp_q;
  assign idle_o = (ph_q == PH_IDLE);
  assign done_o = (ph_q == PH_HI) && (cnt_q == '0);

  // R1
  low_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LO && $past(ph_q == PH_LO)) |-> ($stable(dat_q) && $stable(oe_q)));

  // R1
  fall_on_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dck_q) |-> $past(go_i));
endmodule

// File: rtl/twd_rstgen.sv
module twd_rstgen #(
  parameter int LO_CYC = 2500,
  parameter int HI_CYC = 700
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic dck_low_o,
  output logic done_o
);
  localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int RCW  = $clog2(MAXC + 1);

  typedef enum logic [1:0] {RP_IDLE, RP_LO, RP_HI} rp_e;

  rp_e            ph_q;
  logic [RCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= RP_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        RP_IDLE: if (start_i) begin
          ph_q  <= RP_LO;
          cnt_q <= RCW'(LO_CYC - 1);
        end
        RP_LO: if (cnt_q == '0) begin
          ph_q  <= RP_HI;
          cnt_q <= RCW'(HI_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        RP_HI: if (cnt_q == '0) ph_q <= RP_IDLE;
               else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= RP_IDLE;
      endcase
    end
  end

  assign dck_low_o = (ph_q == RP_LO);
  assign done_o    = (ph_q == RP_HI) && (cnt_q == '0);
endmodule

// File: rtl/twd_frame.sv
module twd_frame
  import twd_pkg::*;
#(
  parameter int WAIT_MAX = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        len_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              link_rst_i,
  input  logic              phy_done_i,
  input  logic              phy_idle_i,
  input  logic              smp_i,
  input  logic              rst_done_i,
  output logic              go_o,
  output logic              bit_o,
  output logic              oe_o,
  output logic              rst_start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WCW = $clog2(WAIT_MAX + 1);

  seq_e              st_q;
  op_e               op_q;
  logic [1:0]        len_q;
  logic [DATA_W-1:0] sh_q, rdata_q;
  logic [BIT_CW-1:0] cnt_q;
  logic [WCW-1:0]    wcnt_q;
  logic              issue_q;
  logic [1:0]        stat_q;
  logic [BIT_CW-1:0] last_bit;

  assign last_bit = {len_q, 3'b111};

  always_comb begin
    bit_o = 1'b0;
    oe_o  = 1'b0;
    unique case (st_q)
      S_START: bit_o = 1'b1;
      S_INS: begin
        bit_o = cnt_q[0] ? ~op_q[1] : ~op_q[0];
        oe_o  = 1'b1;
      end
      S_LEN: begin
        bit_o = len_q[cnt_q[0]];
        oe_o  = 1'b1;
      end
      S_ADDR, S_WDAT: begin
        bit_o = sh_q[0];
        oe_o  = 1'b1;
      end
      S_STOP:  bit_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_AWR;
      len_q   <= '0;
      sh_q    <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      issue_q <= 1'b0;
      stat_q  <= STAT_OK;
    end else begin
      issue_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (link_rst_i) begin
            st_q <= S_LRST;
          end else if (req_i) begin
            op_q    <= op_e'(op_i);
            len_q   <= op_i[1] ? len_i : 2'd0;
            sh_q    <= op_i[1] ? wdata_i : {{(DATA_W-8){1'b0}}, addr_i};
            rdata_q <= '0;
            cnt_q   <= '0;
            wcnt_q  <= '0;
            issue_q <= 1'b1;
            st_q    <= S_START;
          end
        end
        S_LRST: if (rst_done_i) begin
          stat_q <= STAT_OK;
          st_q   <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: if (phy_done_i) begin
          issue_q <= 1'b1;
          case (st_q)
            S_START: begin
              st_q  <= S_INS;
              cnt_q <= '0;
            end
            S_INS: if (!cnt_q[0]) begin
              cnt_q <= 1;
            end else begin
              cnt_q <= '0;
              if (op_q[1])             st_q <= S_LEN;
              else if (op_q == OP_AWR) st_q <= S_ADDR;
              else                     st_q <= S_TURN;
            end
            S_LEN: if (!cnt_q[0]) begin
              cnt_q <= 1;
            end else begin
              cnt_q <= '0;
              st_q  <= (op_q == OP_DWR) ? S_WDAT : S_TURN;
            end
            S_ADDR: begin
              sh_q <= sh_q >> 1;
              if (cnt_q == BIT_CW'(7)) begin
                cnt_q <= '0;
                st_q  <= S_STOP;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            S_WDAT: begin
              sh_q <= sh_q >> 1;
              if (cnt_q == last_bit) begin
                cnt_q <= '0;
                st_q  <= S_TURN;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            S_STOP: begin
              issue_q <= 1'b0;
              stat_q  <= STAT_OK;
              st_q    <= S_DONE;
            end
            S_TURN: begin
              cnt_q  <= '0;
              wcnt_q <= '0;
              st_q   <= (op_q == OP_ARD) ? S_RDAT : S_WAIT;
            end
            S_WAIT: begin
              if (smp_i) begin
                if (op_q == OP_DWR) begin
                  issue_q <= 1'b0;
                  stat_q  <= STAT_OK;
                  st_q    <= S_DONE;
                end else begin
                  cnt_q <= '0;
                  st_q  <= S_RDAT;
                end
              end else if (wcnt_q == WCW'(WAIT_MAX - 1)) begin
                issue_q <= 1'b0;
                stat_q  <= STAT_TMO;
                st_q    <= S_DONE;
              end else begin
                wcnt_q <= wcnt_q + 1'b1;
              end
            end
            S_RDAT: begin
              rdata_q[cnt_q] <= smp_i;
              if (cnt_q == last_bit) begin
                issue_q <= 1'b0;
                stat_q  <= STAT_OK;
                st_q    <= S_DONE;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: st_q <= S_IDLE;
          endcase
        end
      endcase
    end
  end

  assign go_o        = issue_q;
  assign rst_start_o = (st_q == S_IDLE) && link_rst_i;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign status_o    = stat_q;
  assign rdata_o     = rdata_q;

  // R10
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> phy_idle_i);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/twd_master.sv
module twd_master
  import twd_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int WAIT_MAX   = 128,
  parameter int RST_LO_CYC = 2500,
  parameter int RST_HI_CYC = 700
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        len_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              link_rst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dck_o,
  input  logic              dat_i,
  output logic              dat_o,
  output logic              dat_oe_o
);
  logic go, tx_bit, tx_oe, smp, phy_idle, phy_done, phy_dck;
  logic rst_start, rst_low, rst_done;

  twd_frame #(.WAIT_MAX(WAIT_MAX)) u_frame (
    .clk_i, .rst_ni, .req_i, .op_i, .len_i, .addr_i, .wdata_i, .link_rst_i,
    .phy_done_i (phy_done),
    .phy_idle_i (phy_idle),
    .smp_i      (smp),
    .rst_done_i (rst_done),
    .go_o       (go),
    .bit_o      (tx_bit),
    .oe_o       (tx_oe),
    .rst_start_o(rst_start),
    .busy_o, .done_o, .status_o, .rdata_o
  );

  twd_bitcyc #(.DIV(DIV)) u_bitcyc (
    .clk_i, .rst_ni,
    .go_i   (go),
    .bit_i  (tx_bit),
    .oe_i   (tx_oe),
    .dat_i,
    .dck_o  (phy_dck),
    .dat_o,
    .oe_o   (dat_oe_o),
    .smp_o  (smp),
    .idle_o (phy_idle),
    .done_o (phy_done)
  );

  twd_rstgen #(.LO_CYC(RST_LO_CYC), .HI_CYC(RST_HI_CYC)) u_rstgen (
    .clk_i, .rst_ni,
    .start_i  (rst_start),
    .dck_low_o(rst_low),
    .done_o   (rst_done)
  );

  assign dck_o = phy_dck & ~rst_low;

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dat_oe_o);

  // R9
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_low |-> (phy_dck && phy_idle));
endmodule

// File: tb/test_twd_master.sv
module test_twd_master;
  localparam int DIV = 2;
  localparam int RLO = 2500;
  localparam int RHI = 700;

  logic        clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, link_rst_i = 1'b0, dat_i = 1'b0;
  logic [1:0]  op_i = '0, len_i = '0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        busy_o, done_o, dck_o, dat_o, dat_oe_o;
  logic [1:0]  status_o;
  logic [31:0] rdata_o;

  always #5 clk_i = ~clk_i;

  twd_master #(.DIV(DIV), .RST_LO_CYC(RLO), .RST_HI_CYC(RHI)) i_twd_master (
    .clk_i, .rst_ni, .req_i, .op_i, .len_i, .addr_i, .wdata_i, .link_rst_i,
    .busy_o, .done_o, .status_o, .rdata_o, .dck_o, .dat_i, .dat_o, .dat_oe_o
  );

  int checks = 0, errors = 0;
  bit tgt_en = 0;
  int idx = 0;
  bit resp [0:511];
  bit cap_b [0:511];
  bit cap_oe [0:511];
  bit eb [0:511];
  bit eo [0:511];
  int elen = 0;
  int lowrun = 0, bad_low = 0, ndone = 0, bad_done = 0;
  bit done_prev = 0;

  // target model: drives after the falling edge, records at the rising edge
  always @(negedge dck_o) if (tgt_en) dat_i <= resp[idx];
  always @(posedge dck_o) if (tgt_en) begin
    if (idx < 512) begin
      cap_b[idx]  = dat_o;
      cap_oe[idx] = dat_oe_o;
    end
    idx++;
  end

  always @(negedge clk_i) begin
    if (tgt_en) begin
      if (dck_o == 1'b0) lowrun++;
      else if (lowrun != 0) begin
        if (lowrun != DIV) bad_low++;
        lowrun = 0;
      end
    end
    if (done_o) ndone++;
    if (done_o && done_prev) bad_done++;
    done_prev = done_o;
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(bit o, bit b);
    eo[elen] = o;
    eb[elen] = b;
    elen++;
  endtask

  task automatic run(logic [1:0] op, logic [1:0] len, logic [7:0] addr, logic [31:0] wd,
                     int nz, logic [31:0] rv, bit extra_req);
    int nb, t, bad, dn0;
    bit tmo;
    logic [31:0] mask, exp_rd;
    logic [1:0] st;
    logic [31:0] rd;
    string tag;
    elen = 0;
    for (int i = 0; i < 512; i++) resp[i] = 1'b0;
    nb  = op[1] ? 8 * (int'(len) + 1) : 8;
    tmo = op[1] && (nz >= 128);
    // R2 start, R3 instruction, R4 length
    push(1'b0, 1'b1);
    push(1'b1, ~op[0]);
    push(1'b1, ~op[1]);
    if (op[1]) begin push(1'b1, len[0]); push(1'b1, len[1]); end
    case (op)
      2'd0: begin
        for (int i = 0; i < 8; i++) push(1'b1, addr[i]);
        push(1'b0, 1'b1);
      end
      2'd1: begin
        push(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin resp[elen] = rv[i]; push(1'b0, rv[i]); end
      end
      default: begin
        if (op == 2'd2) for (int i = 0; i < nb; i++) push(1'b1, wd[i]);
        push(1'b0, 1'b0);
        if (tmo) for (int i = 0; i < 128; i++) push(1'b0, 1'b0);
        else begin
          for (int i = 0; i < nz; i++) push(1'b0, 1'b0);
          resp[elen] = 1'b1;
          push(1'b0, 1'b1);
          if (op == 2'd3)
            for (int i = 0; i < nb; i++) begin resp[elen] = rv[i]; push(1'b0, rv[i]); end
        end
      end
    endcase
    tag = (op == 2'd0) ? "R5" : (op == 2'd1) ? "R6" : tmo ? "R8" : "R7";
    idx = 0;
    lowrun = 0;
    tgt_en = 1;
    dn0 = ndone;
    @(negedge clk_i);
    op_i = op; len_i = len; addr_i = addr; wdata_i = wd; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after accept", busy_o, 1);
    if (extra_req) begin
      repeat (20) @(negedge clk_i);
      op_i = 2'd3; len_i = 2'd3; req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk_i); t++; end
    st = status_o;
    rd = rdata_o;
    chk(st == (tmo ? 2'd1 : 2'd0), tag, "status", st, tmo ? 1 : 0);
    chk(idx == elen, tag, "frame bit count", idx, elen);
    bad = -1;
    for (int i = 0; i < elen && i < idx; i++)
      if (bad < 0 && (cap_oe[i] != eo[i] || (eo[i] && cap_b[i] != eb[i]))) bad = i;
    chk(bad < 0, "R2/R3/R4", "first bad frame bit", bad, -1);
    if (op[0]) begin
      mask = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
      exp_rd = tmo ? 32'd0 : (rv & mask);
      chk(rd == exp_rd, tag, "read data", rd, exp_rd);
    end
    repeat (40) @(negedge clk_i);
    if (extra_req) begin
      chk(busy_o == 1'b0, "R10", "request while busy ignored, busy", busy_o, 0);
      chk(ndone == dn0 + 1, "R10", "request while busy ignored, done count", ndone - dn0, 1);
    end
    tgt_en = 0;
  endtask

  bit wd_fired = 0;
  initial begin
    #(200000 * 10);
    wd_fired = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi;
    logic [7:0]  apat [4];
    logic [31:0] dpat [3];
    apat[0] = 8'hA5; apat[1] = 8'h3C; apat[2] = 8'h01; apat[3] = 8'h80;
    dpat[0] = 32'hC3A5_1E69; dpat[1] = 32'h8000_0001; dpat[2] = 32'h5F0E_D27B;
    repeat (4) @(negedge clk_i);
    // R1 / R10 reset state
    chk(dck_o == 1'b1, "R1", "idle clock", dck_o, 1);
    chk(dat_oe_o == 1'b0, "R1", "idle driver", dat_oe_o, 0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R10", "idle busy/done", {busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R9 link reset, priority over a simultaneous frame request
    link_rst_i = 1'b1; req_i = 1'b1; op_i = 2'd0;
    @(negedge clk_i);
    link_rst_i = 1'b0; req_i = 1'b0;
    lo = 0; hi = 0;
    while (!done_o && (lo + hi) < 10000) begin
      if (dck_o == 1'b0) lo++; else hi++;
      @(negedge clk_i);
    end
    chk(lo == RLO, "R9", "reset low cycles", lo, RLO);
    chk(hi == RHI, "R9", "reset high cycles", hi, RHI);
    chk(status_o == 2'd0, "R9", "reset status", status_o, 0);
    repeat (10) @(negedge clk_i);
    chk(busy_o == 1'b0 && dck_o == 1'b1, "R9", "frame request dropped", busy_o, 0);

    // R5 / R6 address operations
    for (int a = 0; a < 4; a++) begin
      run(2'd0, 2'd0, apat[a], 32'd0, 0, 32'd0, 1'b0);
      run(2'd1, 2'd0, 8'd0, 32'd0, 0, {24'd0, apat[3 - a]}, 1'b0);
    end
    // R7 / R4 data operations over all lengths
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 3; p++) begin
        run(2'd2, 2'(l), 8'd0, dpat[p], (p == 0) ? 0 : 3, 32'd0, 1'b0);
        run(2'd3, 2'(l), 8'd0, 32'd0, (p == 1) ? 0 : 3, dpat[2 - p], 1'b0);
      end
    end
    // R8 wait boundary and timeout
    run(2'd3, 2'd1, 8'd0, 32'd0, 127, 32'hBEEF_1234, 1'b0);
    run(2'd2, 2'd0, 8'd0, 32'h0000_005A, 127, 32'd0, 1'b0);
    run(2'd2, 2'd2, 8'd0, 32'h0012_3456, 128, 32'd0, 1'b0);
    run(2'd3, 2'd3, 8'd0, 32'd0, 300, 32'hFFFF_FFFF, 1'b0);
    // R10 request while busy
    run(2'd0, 2'd0, 8'h5A, 32'd0, 0, 32'd0, 1'b1);
    run(2'd3, 2'd0, 8'd0, 32'd0, 2, 32'h0000_00C6, 1'b1);

    chk(bad_low == 0, "R1", "low phases not DIV cycles", bad_low, 0);
    chk(bad_done == 0, "R10", "done wider than one cycle", bad_done, 0);
    if (!wd_fired) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule